// File: doc/BRIEF.md
# Periodic Tick Timer with Interrupt

This block is a free-running tick source for a processor subsystem. A single 32-bit control/status word sets the period and the mode, and a hidden 28-bit down-counter generates the ticks. Each clock in which the timer is enabled, the block checks whether the counter has reached zero. In that case it reloads the counter from the period field, unless the single-run mode is selected. If interrupts are enabled, it also latches a sticky pending flag that drives a level-sensitive interrupt request.

Software programs the timer through a plain register write port and reads the control word back on a combinational read port. A write changes the period, the mode bits and the pending flag, but it leaves the running count alone. A new period therefore starts at the next zero event. The counter comes out of reset at zero, so the first enabled cycle produces a tick at once.

Top module: `tick_timer`

## Requirements
- R1: A synchronous reset clears the whole control word and the internal counter: `rdData` reads 0 and `irq` is low. The first enabled cycle after reset is a zero event.
- R2: Control word layout: bit 31 enable, bit 30 single-run, bit 29 interrupt-enable, bit 28 pending, bits 27:0 period. A write stores all 32 bits, and `rdData` returns the stored word.
- R3: With enable set, single-run clear and period P >= 1, zero events occur on the first enabled cycle and then every P enabled cycles. With P = 0, every enabled cycle is a zero event.
- R4: While enable is clear, the counter holds its value and no zero event happens. When enable is set again, counting resumes from the held value, so the tick phase is kept.
- R5: A zero event sets the pending bit when interrupt-enable is set. With interrupt-enable clear, a zero event leaves the pending bit unchanged.
- R6: The pending bit is sticky: only a write with bit 28 = 0 clears it. When a hardware set and a clearing write fall in the same cycle, the bit ends up set.
- R7: When single-run is set and the counter reaches zero, no reload happens. The counter stays at zero, and every following enabled cycle is a zero event.
- R8: A register write never changes the internal counter. A changed period is first loaded at the next zero event.
- R9: `irq` is a level equal to the pending bit AND interrupt-enable of the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word value to write |
| rdData | output | 32 | Current control word |
| irq | output | 1 | Level interrupt request |

## Verification
The main sweep runs every period from 0 to 9, with interrupts on and off. It clears the pending bit on every cycle, so the pending bit after each edge shows exactly whether that edge was a zero event. This separates an off-by-one period, a missing first tick and a wrong P = 0 case. Further patterns insert a disabled gap in mid-count, switch to single-run or to a new period in mid-count, and hold or clear the pending bit without writes. These tell apart a lost phase, a counter reset on write, a wrong reload priority, a non-sticky flag and a clear that wins over a hardware set. Expected tick positions come from modulo arithmetic on the count of enabled cycles.

// File: rtl/tick_pkg.sv
package tick_pkg;

  // Strobes from the control section to the counter datapath
  typedef struct packed {
    logic run;      // counter advances this cycle
    logic reload;   // load the period before decrementing
    logic setPend;  // zero event with interrupts enabled
  } tickStrobe_t;

endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int CNT_W = 28,
  localparam int REG_W = CNT_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             cntZero,
  output logic [REG_W-1:0] csr,
  output logic [CNT_W-1:0] period,
  output tickStrobe_t      strb,
  output logic             irq
);

  localparam int EN_BIT   = REG_W - 1;
  localparam int SR_BIT   = REG_W - 2;
  localparam int IE_BIT   = REG_W - 3;
  localparam int PEND_BIT = REG_W - 4;

  logic enBit, srBit, ieBit, pendBit;

  assign enBit   = csr[EN_BIT];
  assign srBit   = csr[SR_BIT];
  assign ieBit   = csr[IE_BIT];
  assign pendBit = csr[PEND_BIT];
  assign period  = csr[CNT_W-1:0];

  logic zeroEvt;
  assign zeroEvt = enBit & cntZero;

  always_comb begin
    strb         = '0;
    strb.run     = enBit;
    strb.reload  = zeroEvt & ~srBit;
    strb.setPend = zeroEvt & ieBit;
  end

  // Control word: a write loads every field, a hardware set of pending wins
  always_ff @(posedge clk) begin
    if (rst) begin
      csr <= '0;
    end else begin
      if (wrEn) csr <= wrData;
      if (strb.setPend) csr[PEND_BIT] <= 1'b1;
    end
  end

  assign irq = pendBit & ieBit;

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pendBit && !wrEn) |=> pendBit);

  // R6
  pend_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (zeroEvt && ieBit && wrEn && !wrData[PEND_BIT]) |=> pendBit);

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    (zeroEvt && ieBit) |=> pendBit);

  // R5
  pend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!pendBit && !wrEn && !(zeroEvt && ieBit)) |=> !pendBit);

endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  tickStrobe_t      strb,
  input  logic [CNT_W-1:0] period,
  output logic             cntZero
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loaded;
  logic [CNT_W-1:0] cntNext;

  // Zero check and optional reload first, then decrement if nonzero
  always_comb begin
    loaded  = strb.reload ? period : cnt;
    cntNext = (loaded != '0) ? loaded - 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strb.run) begin
      cnt <= cntNext;
    end
  end

  assign cntZero = (cnt == '0);

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.run |=> $stable(cnt));

  // R3
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    strb.reload |=> (cnt == (($past(period) == '0) ? '0 : $past(period) - 1'b1)));

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.run && !strb.reload && !cntZero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 28,
  localparam int REG_W = CNT_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             irq
);

  localparam int EN_BIT   = REG_W - 1;
  localparam int SR_BIT   = REG_W - 2;
  localparam int IE_BIT   = REG_W - 3;
  localparam int PEND_BIT = REG_W - 4;

  tickStrobe_t      strb;
  logic             cntZero;
  logic [REG_W-1:0] csr;
  logic [CNT_W-1:0] period;

  tick_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrData (wrData),
    .cntZero(cntZero),
    .csr    (csr),
    .period (period),
    .strb   (strb),
    .irq    (irq)
  );

  tick_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .period (period),
    .cntZero(cntZero)
  );

  assign rdData = csr;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rdData == '0 && !irq && cntZero));

  // R7
  single_run_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (csr[EN_BIT] && csr[SR_BIT] && cntZero) |=> cntZero);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (rdData[PEND_BIT] && rdData[IE_BIT]));

endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;

  localparam int CNT_W = 28;
  localparam int REG_W = CNT_W + 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             wrEn;
  logic [REG_W-1:0] wrData;
  logic [REG_W-1:0] rdData;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W)) i_tick_timer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  function automatic logic [31:0] mk(input bit en, input bit sr, input bit ie, input int p);
    mk = {en, sr, ie, 1'b0, p[27:0]};
  endfunction

  localparam logic [31:0] PEND = 32'h1000_0000;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, take one posedge, return at next negedge for sampling
  task automatic step(input logic we, input logic [31:0] d);
    wrEn = we;
    wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic stepChk(input logic we, input logic [31:0] d, input bit expPend,
                         input bit expIrq, input string tag);
    step(we, d);
    chk({31'b0, rdData[28]}, {31'b0, expPend}, {tag, " pending"});
    chk({31'b0, irq}, {31'b0, expIrq}, {tag, " irq"});
  endtask

  task automatic doReset();
    rst = 1'b1;
    step(1'b0, '0);
    step(1'b0, '0);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wrEn = 1'b0;
    wrData = '0;
    rst = 1'b1;
    @(negedge clk);
    doReset();

    // R1: reset state
    chk(rdData, 32'h0, "R1 rdData after reset");
    chk({31'b0, irq}, 32'h0, "R1 irq after reset");

    // R2: readback of every field, timer kept disabled
    step(1'b1, 32'h6ABC_DEF1);
    chk(rdData, 32'h6ABC_DEF1, "R2 readback");
    step(1'b1, 32'h1234_5678);
    chk(rdData, 32'h1234_5678, "R2 readback 2");
    chk({31'b0, irq}, 32'h0, "R9 pending without ie");

    // R3/R5: sweep periods and ie, clearing pending every cycle
    for (int ie = 0; ie < 2; ie++) begin
      for (int p = 0; p < 10; p++) begin
        doReset();
        step(1'b1, mk(1, 0, ie[0], p));
        chk(rdData, mk(1, 0, ie[0], p), "R2 stored word");
        for (int j = 0; j < 3 * p + 4; j++) begin
          bit evt;
          evt = (p == 0) || (j % p == 0);
          stepChk(1'b1, mk(1, 0, ie[0], p), evt && ie[0], evt && ie[0],
                  ie[0] ? "R3 period sweep" : "R5 ie clear");
        end
      end
    end

    // R4: disabled gap keeps the phase
    begin
      int idx;
      doReset();
      step(1'b1, mk(1, 0, 1, 5));
      for (idx = 0; idx < 2; idx++)
        stepChk(1'b1, mk(1, 0, 1, 5), idx == 0, idx == 0, "R4 pre-gap");
      stepChk(1'b1, mk(0, 0, 1, 5), 1'b0, 1'b0, "R4 disabling edge");
      idx = 3;
      for (int g = 0; g < 7; g++)
        stepChk(1'b1, mk(0, 0, 1, 5), 1'b0, 1'b0, "R4 hold while off");
      stepChk(1'b1, mk(1, 0, 1, 5), 1'b0, 1'b0, "R4 enabling edge");
      for (; idx < 12; idx++)
        stepChk(1'b1, mk(1, 0, 1, 5), idx % 5 == 0, idx % 5 == 0, "R4 resumed phase");
    end

    // R7: single-run from reset ticks every cycle
    doReset();
    step(1'b1, mk(1, 1, 1, 7));
    for (int j = 0; j < 6; j++)
      stepChk(1'b1, mk(1, 1, 1, 7), 1'b1, 1'b1, "R7 single-run at zero");

    // R7: switch to single-run mid-count (count 3 left before idx 3)
    doReset();
    step(1'b1, mk(1, 0, 1, 6));
    for (int j = 0; j < 3; j++)
      stepChk(1'b1, mk(1, 0, 1, 6), j == 0, j == 0, "R7 periodic lead-in");
    for (int j = 3; j < 12; j++)
      stepChk(1'b1, mk(1, 1, 1, 6), j >= 6, j >= 6, "R7 run down then stay");

    // R8: period change mid-count takes effect at next zero
    doReset();
    step(1'b1, mk(1, 0, 1, 8));
    for (int j = 0; j < 3; j++)
      stepChk(1'b1, mk(1, 0, 1, 8), j == 0, j == 0, "R8 old period");
    for (int j = 3; j < 18; j++) begin
      bit evt;
      evt = (j >= 8) && ((j - 8) % 3 == 0);
      stepChk(1'b1, mk(1, 0, 1, 3), evt, evt, "R8 new period");
    end

    // R6/R9: sticky pending, irq gating by ie
    doReset();
    step(1'b1, mk(1, 0, 1, 4));
    for (int j = 0; j < 6; j++)
      stepChk(1'b0, '0, 1'b1, 1'b1, "R6 sticky without writes");
    stepChk(1'b1, mk(0, 0, 0, 4) | PEND, 1'b1, 1'b0, "R9 ie off masks irq");
    stepChk(1'b1, mk(0, 0, 1, 4) | PEND, 1'b1, 1'b1, "R9 ie on drives irq");
    stepChk(1'b1, mk(0, 0, 1, 4), 1'b0, 1'b0, "R6 software clear");
    for (int j = 0; j < 3; j++)
      stepChk(1'b0, '0, 1'b0, 1'b0, "R6 stays clear");

    // R6: hardware set wins over clearing write
    doReset();
    step(1'b1, mk(1, 0, 1, 0));
    stepChk(1'b0, '0, 1'b1, 1'b1, "R6 first set");
    stepChk(1'b1, mk(1, 0, 1, 0), 1'b1, 1'b1, "R6 set beats clear");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule